// File: doc/BRIEF.md
# DAC Sample Feeder with Paced Release

This block sits between a register-write port and a digital-to-analog converter core. Software pushes conversion words through a valid/ready write strobe into a four-entry queue. The block hands these words to the converter one at a time. Each hand-off is a one-cycle start pulse that comes with a held data word. Everything runs on the single system clock.

A release happens only when three things hold in the same cycle: the block is enabled, the queue is not empty, and a trigger event occurs. The trigger comes from one of two sources. The first is an internal tick that the system clock produces through a programmable divider. The second is a rising edge on one of several external trigger pins, chosen by a select field. When the external-source bit is clear, the internal tick paces the releases.

Clearing the enable bit empties the queue. A write into a full queue is dropped and raises a sticky overrun flag.

Top module: `dac_feeder`

## Requirements
- R1: After reset, fill_count is 0, conv_start is 0, conv_data is 0 and overrun is 0. wr_ready is 0 while cfg_en is 0.
- R2: wr_ready is high when cfg_en is 1 and fewer than 4 words are queued. A write with wr_valid and wr_ready both high raises fill_count by one at the next clock edge.
- R3: A write while cfg_en is 1 and 4 words are queued does not change the queue contents and sets overrun. overrun stays at 1 until reset.
- R4: Words leave the queue in the order they were written. An accepted trigger at a clock edge pops the oldest word to conv_data, lowers fill_count by one and drives conv_start high for exactly the following cycle. conv_data holds its value when conv_start is 0.
- R5: With cfg_ext_en at 0, internal ticks come every 2*(cfg_div+1) cycles. After enabling, or after switching to internal mode, the first conversion appears on conv_start exactly 2*(cfg_div+1) cycles after the cycle in which the change was driven.
- R6: Rewriting cfg_div to a new value restarts the tick counter. The next conversion appears 1 + 2*(new cfg_div+1) cycles after the cycle in which the new value was driven.
- R7: With cfg_ext_en at 1, each rising edge on ext_trig[cfg_ext_sel] releases exactly one word, and conv_start rises 3 cycles after the edge is driven. A pin that stays high gives no further releases. Pins that are not selected have no effect.
- R8: Clearing cfg_ext_en puts the block under internal-tick pacing, following the R5 timing.
- R9: A trigger that arrives while the queue is empty is discarded. A word written afterwards waits for the next trigger, which in internal mode falls on the running tick grid.
- R10: While cfg_en is 0, the queue is flushed to fill_count 0 at the next edge, writes are dropped without setting overrun, and no conversion starts. After re-enabling, a trigger with an empty queue leaves conv_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Block enable; low flushes the queue |
| cfg_ext_en | input | 1 | 1 selects external pin pacing, 0 selects internal ticks |
| cfg_ext_sel | input | SEL_W (1) | Index of the external trigger pin in use |
| cfg_div | input | DIV_W (8) | Divider; the tick period is 2*(cfg_div+1) cycles |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W (12) | Conversion word to queue |
| wr_ready | output | 1 | Queue can take a word |
| fill_count | output | CNT_W (3) | Number of queued words |
| overrun | output | 1 | Sticky flag for a write into a full queue |
| ext_trig | input | NUM_EXT (2) | Asynchronous external trigger pins |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_data | output | DATA_W (12) | Word being converted; held between starts |

## Verification
The release path is driven in three ways. The first is a full queue drained by internal ticks at two divider settings. The second is single and held edges on the selected external pin, while the pin that is not selected toggles. The third is triggers that arrive against an empty queue. Cycle-exact start times tell a correct divider restart apart from a free-running counter, and the synchronizer latency apart from an unsynchronized edge. Draining after an overrun shows that a dropped word is really missing from the queue and was not written over an older one. A flush followed by a pin edge shows that no stale word or trigger survives a disable.

// File: rtl/dacf_pkg.sv
// Package: shared types for the DAC sample feeder.
// Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package dacf_pkg;
    // Pacing source currently in effect.
    typedef enum logic {
        SRC_TICK = 1'b0,
        SRC_PIN  = 1'b1
    } pace_src_e;
endpackage

// File: rtl/dacf_queue.sv
// Module: dacf_queue
// A circular word queue of DEPTH entries. Push and pop arrive already
// qualified: the caller never pushes when full and never pops when empty.
// A flush empties it in one cycle. head always shows the oldest entry.
module dacf_queue #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wp, rp;

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wp] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Show the oldest word.
    assign head = slots[rp];
endmodule

// File: rtl/dacf_tick_gen.sv
// Module: dacf_tick_gen
// Makes a one-cycle tick every 2*(div+1) cycles while run is high. The
// counter is held at zero while run is low, and it restarts in the cycle
// after div takes a new value. No tick is issued during that cycle.
module dacf_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W:0]   cnt;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   limit;
    logic             reload;

    // The terminal count 2*div+1 is the divider with a low 1 appended.
    assign limit  = {div, 1'b1};
    assign reload = !run || (div != div_q);

    // Track the divider and run the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= '0;
        end else begin
            div_q <= div;
            if (reload || cnt == limit) cnt <= '0;
            else                        cnt <= cnt + 1'b1;
        end
    end

    // Fire in the last cycle of each period.
    assign tick = !reload && (cnt == limit);
endmodule

// File: rtl/dacf_pin_edge.sv
// Module: dacf_pin_edge
// Passes each asynchronous trigger pin through two synchronizing flops.
// A third flop turns each low-to-high change into exactly one
// single-cycle pulse.
module dacf_pin_edge #(
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] pins,
    output logic [NUM_EXT-1:0] rise
);
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        logic [2:0] sh;

        // Synchronize the pin and keep one extra stage for the edge compare.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], pins[g]};
        end

        // Pulse when the synchronized level goes from low to high.
        assign rise[g] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/dac_feeder.sv
// Module: dac_feeder (top)
// Queues conversion words and releases one per accepted trigger. A trigger
// is accepted only while enabled and with data queued. The trigger is an
// internal divided tick or a synchronized pin edge.
// Assumes a single system clock, and NUM_EXT of 2 or more.
module dac_feeder #(
    parameter int DATA_W  = 12,
    parameter int DEPTH   = 4,
    parameter int DIV_W   = 8,
    parameter int NUM_EXT = 2,
    localparam int SEL_W  = $clog2(NUM_EXT),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_ext_en,
    input  logic [SEL_W-1:0]   cfg_ext_sel,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               wr_ready,
    output logic [CNT_W-1:0]   fill_count,
    output logic               overrun,
    input  logic [NUM_EXT-1:0] ext_trig,
    output logic               conv_start,
    output logic [DATA_W-1:0]  conv_data
);
    import dacf_pkg::*;

    pace_src_e          src;
    logic               tick, pin_pulse, trig, push, pop, full;
    logic [NUM_EXT-1:0] rise;
    logic [DATA_W-1:0]  head;

    // Pick the pacing source; a clear external bit means internal ticks.
    assign src = cfg_ext_en ? SRC_PIN : SRC_TICK;

    dacf_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(cfg_en && src == SRC_TICK),
        .div(cfg_div), .tick(tick)
    );

    dacf_pin_edge #(.NUM_EXT(NUM_EXT)) edge_i (
        .clk(clk), .rst_n(rst_n), .pins(ext_trig), .rise(rise)
    );

    // Select the pin pulse and merge it with the tick into one trigger.
    assign pin_pulse = rise[cfg_ext_sel];
    assign trig      = (src == SRC_PIN) ? pin_pulse : tick;

    // Qualify writes and releases against enable and occupancy.
    assign full     = (fill_count == CNT_W'(DEPTH));
    assign wr_ready = cfg_en && !full;
    assign push     = wr_valid && wr_ready;
    assign pop      = cfg_en && trig && (fill_count != '0);

    dacf_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
        .clk(clk), .rst_n(rst_n), .flush(!cfg_en), .push(push),
        .push_data(wr_data), .pop(pop), .head(head), .count(fill_count)
    );

    // Register the start pulse and hold the converted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_data  <= '0;
        end else begin
            conv_start <= pop;
            if (pop) conv_data <= head;
        end
    end

    // Latch a write into a full queue until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (cfg_en && wr_valid && full) overrun <= 1'b1;
    end
endmodule

// File: rtl/dac_feeder_chk.sv
// Module: dac_feeder_chk
// Property checker attached to dac_feeder by the bind statement below.
// It relates the ports over time and drives nothing.
module dac_feeder_chk #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CNT_W-1:0]  fill_count,
    input logic              overrun,
    input logic              conv_start,
    input logic [DATA_W-1:0] conv_data
);
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH);

    assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_en) |-> (int'(fill_count) <= int'($past(fill_count)) + 1 &&
                           int'(fill_count) + 1 >= int'($past(fill_count))));

    assert_ready_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (cfg_en && int'(fill_count) < DEPTH));

    assert_full_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && wr_valid && int'(fill_count) == DEPTH) |=> overrun);

    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(conv_data));

    assert_start_needs_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(fill_count) != '0 && $past(cfg_en)));

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (fill_count == '0 && !conv_start));
endmodule

bind dac_feeder dac_feeder_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .fill_count(fill_count), .overrun(overrun),
    .conv_start(conv_start), .conv_data(conv_data)
);

// File: tb/dac_feeder_tb_top.sv
// Directed bench for dac_feeder: one task per scenario, each checking
// its own results. Inputs change 1 ns after a rising edge, and outputs are
// sampled at that same point.
module dac_feeder_tb_top;
    localparam int DATA_W = 12, DEPTH = 4, DIV_W = 8, NUM_EXT = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_en = 1'b0, cfg_ext_en = 1'b0;
    logic [0:0]         cfg_ext_sel = '0;
    logic [DIV_W-1:0]   cfg_div = '0;
    logic               wr_valid = 1'b0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [NUM_EXT-1:0] ext_trig = '0;
    logic               wr_ready, overrun, conv_start;
    logic [2:0]         fill_count;
    logic [DATA_W-1:0]  conv_data;

    int  cyc = 0, n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_feeder #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W), .NUM_EXT(NUM_EXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ext_en(cfg_ext_en),
        .cfg_ext_sel(cfg_ext_sel), .cfg_div(cfg_div), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .fill_count(fill_count),
        .overrun(overrun), .ext_trig(ext_trig), .conv_start(conv_start),
        .conv_data(conv_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic put(input logic [DATA_W-1:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic wait_start(input int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            tick();
            if (conv_start) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        logic [DATA_W-1:0] held = conv_data;
        for (int i = 0; i < n; i++) begin
            tick();
            if (conv_start || conv_data != held) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic pin_pulse(input int idx);
        ext_trig[idx] = 1'b1;
        tick(); tick();
        ext_trig[idx] = 1'b0;
    endtask

    // R1: values right after reset.
    task automatic t_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(fill_count == 0, "R1 fill", fill_count, 0);
        check(!conv_start && conv_data == 0, "R1 conv", conv_data, 0);
        check(!overrun, "R1 overrun", overrun, 0);
        check(!wr_ready, "R1 ready while disabled", wr_ready, 0);
    endtask

    // R2, R4, R5, R9: internal pacing at 4-cycle period with an empty gap.
    task automatic t_tick_drain();
        int d, at, last;
        cfg_en = 1'b1; cfg_ext_en = 1'b1; cfg_div = 8'd1;
        tick();
        for (int i = 0; i < 4; i++) begin
            put(12'h100 + 12'(i));
            check(fill_count == 3'(i + 1), "R2 fill grows", fill_count, i + 1);
        end
        check(!wr_ready, "R2 ready low when full", wr_ready, 0);
        cfg_ext_en = 1'b0;
        d = cyc;
        for (int i = 0; i < 4; i++) begin
            wait_start(20, at);
            check(at == d + 4 * (i + 1), "R5 tick period", at - d, 4 * (i + 1));
            check(conv_data == 12'h100 + 12'(i), "R4 order", conv_data, 12'h100 + i);
            check(fill_count == 3'(3 - i), "R4 fill drops", fill_count, 3 - i);
        end
        last = at;
        quiet(5, "R9 empty trigger discarded");
        put(12'h1AB);
        wait_start(20, at);
        check(at == last + 8, "R9 waits for grid tick", at - last, 8);
        check(conv_data == 12'h1AB, "R9 late word", conv_data, 12'h1AB);
    endtask

    // R6: divider rewrite restarts the period.
    task automatic t_div_restart();
        int d, at;
        cfg_ext_en = 1'b1; cfg_div = 8'd3;
        tick();
        for (int i = 0; i < 3; i++) put(12'h200 + 12'(i));
        cfg_ext_en = 1'b0;
        d = cyc;
        wait_start(30, at);
        check(at == d + 8, "R8 first tick after switch", at - d, 8);
        tick(); tick(); tick();
        cfg_div = 8'd1;
        d = cyc;
        wait_start(30, at);
        check(at == d + 5, "R6 restart on rewrite", at - d, 5);
        check(conv_data == 12'h201, "R6 data", conv_data, 12'h201);
        wait_start(30, at);
        check(at == d + 9, "R6 new period", at - d, 9);
        cfg_en = 1'b0; tick(); cfg_en = 1'b1; tick();
    endtask

    // R7, R8: edges on selected pin; the other pin and a held level do nothing.
    task automatic t_pins();
        int d, at;
        cfg_ext_en = 1'b1; cfg_ext_sel = 1'b1; cfg_div = 8'd0;
        tick();
        for (int i = 0; i < 3; i++) put(12'h300 + 12'(i));
        pin_pulse(0);
        quiet(8, "R7 unselected pin ignored");
        check(fill_count == 3, "R7 fill unchanged", fill_count, 3);
        ext_trig[1] = 1'b1;
        d = cyc;
        wait_start(10, at);
        check(at == d + 3, "R7 edge latency", at - d, 3);
        check(conv_data == 12'h300, "R7 data", conv_data, 12'h300);
        quiet(10, "R7 held level single release");
        ext_trig[1] = 1'b0;
        tick(); tick(); tick();
        ext_trig[1] = 1'b1;
        d = cyc;
        wait_start(10, at);
        check(at == d + 3 && conv_data == 12'h301, "R7 second edge", at - d, 3);
        ext_trig[1] = 1'b0;
        tick(); tick(); tick();
        cfg_ext_en = 1'b0;
        d = cyc;
        wait_start(10, at);
        check(at == d + 2 && conv_data == 12'h302, "R8 fallback to tick", at - d, 2);
    endtask

    // R3: write into a full queue is dropped; flag sticks.
    task automatic t_overrun();
        cfg_ext_en = 1'b1;
        tick(); tick();
        check(!overrun, "R3 no overrun yet", overrun, 0);
        for (int i = 0; i < 4; i++) put(12'h400 + 12'(i));
        put(12'h4FF);
        check(fill_count == 4, "R3 full unchanged", fill_count, 4);
        check(overrun, "R3 overrun set", overrun, 1);
        for (int i = 0; i < 4; i++) begin
            int at;
            pin_pulse(1);
            wait_start(10, at);
            check(at > 0 && conv_data == 12'h400 + 12'(i), "R3 dropped word absent", conv_data, 12'h400 + i);
        end
        quiet(4, "R3 nothing extra queued");
        check(overrun, "R3 overrun sticky", overrun, 1);
    endtask

    // R10: disable flushes, drops writes, blocks conversions.
    task automatic t_disable();
        logic [DATA_W-1:0] prev;
        put(12'h500); put(12'h501);
        check(fill_count == 2, "R10 prefill", fill_count, 2);
        prev = conv_data;
        cfg_en = 1'b0;
        tick();
        check(fill_count == 0 && !wr_ready, "R10 flush", fill_count, 0);
        put(12'h5AA);
        check(fill_count == 0, "R10 write dropped", fill_count, 0);
        cfg_en = 1'b1;
        tick();
        pin_pulse(1);
        quiet(8, "R10 no stale conversion");
        check(conv_data == prev && fill_count == 0, "R10 data held", conv_data, prev);
    endtask

    initial begin
        t_reset();
        t_tick_drain();
        t_div_restart();
        t_pins();
        t_overrun();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end
endmodule